// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block runs hardware loops for a program sequencer, so that a loop body runs back to back with no branch instruction at its end. A loop-start command hands the block the address of the loop's last instruction and a 4-bit termination code. The block keeps these pairs on a four-level stack, one level per nested loop. In the same cycle it asks the surrounding sequencer to save the first body address on the program-counter stack.

Every cycle the block compares the fetch address the sequencer is about to use with the end address of the innermost live loop. A match means the next instruction to run is the last one of the loop. In the cycle that instruction runs, the block tests the stored condition against the live status flags. If the loop goes on, it asks for the next fetch to come from the top of the program-counter stack. If the loop ends, it pops its own stack and the program-counter stack, and fetch falls through to the following address. Loops that end on the down counter also get decrement and count-stack pop requests. A manual pop leaves a loop early. Empty and sticky overflow flags report the stack state.

Top module: `zol_loop_ctrl`

## Requirements
- R1: After a synchronous active-high reset the loop stack is empty (`loop_empty`=1), `loop_ovf`=0, and every request output is 0.
- R2: A loop-start (`do_valid`=1) that the stack can accept stores {`do_end_addr`, `do_cond`} as the new top entry and raises `pc_push_req` in the same cycle.
- R3: `last_next` is 1 in a cycle when `next_addr` equals the end address of the entry that will be on top at the end of that cycle. That entry is the new one during an accepted loop-start, and the one below during a pop. `last_next` is never 1 while the stack is, or becomes, empty.
- R4: In the cycle after `last_next`, the top entry's condition is evaluated. If the loop continues, `loop_back`=1. If it terminates, `pc_pop_req`=1 and the top entry is removed. There is no extra cycle either way.
- R5: The stored code is a branch code, and the loop continues while that branch condition is true. The codes are 0 EQ (z), 1 NE, 2 GT (!lt & !z), 3 LE (lt | z), 4 LT (lt = n ^ v), 5 GE, 6 overflow (v), 7 not v, 8 carry (c), 9 not c, 10 X sign negative (xs), 11 X sign positive, 12 multiplier overflow (mv), 13 not mv, 14 counter not expired (!ce), 15 true. `flags` bits 0..6 are z, n, v, c, xs, mv, ce.
- R6: With code 14, every end-of-loop test raises `cnt_dec_req`. The terminating test also raises `cnt_pop_req`.
- R7: Code 15 never terminates a loop.
- R8: When an inner loop terminates, the comparison in that same cycle already uses the outer loop's end address.
- R9: `man_pop` removes the top entry and raises `pc_pop_req`. On an empty stack it has no effect.
- R10: A loop-start that arrives while the stack is full and nothing pops is discarded. `pc_push_req` stays 0, the stored entries are unchanged, and `loop_ovf` becomes 1 and stays 1 until reset.
- R11: `loop_empty` is 1 exactly when the stack holds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| do_valid | input | 1 | Loop-start command this cycle |
| do_end_addr | input | 14 | Address of the loop's last instruction |
| do_cond | input | 4 | Termination code, branch encoding with inverted sense |
| next_addr | input | 14 | Address the sequencer fetches next |
| flags | input | 7 | Status flags {ce, mv, xs, c, v, n, z} |
| man_pop | input | 1 | Manual pop for early loop exit |
| last_next | output | 1 | Next instruction is the last of the innermost loop |
| loop_back | output | 1 | Take next fetch from program-counter stack top |
| pc_push_req | output | 1 | Push first body address on the program-counter stack |
| pc_pop_req | output | 1 | Pop the program-counter stack |
| cnt_dec_req | output | 1 | Decrement the down counter |
| cnt_pop_req | output | 1 | Pop the count stack |
| loop_empty | output | 1 | Loop stack holds no entry |
| loop_ovf | output | 1 | Sticky: a loop-start was lost to a full stack |

## Verification
The hardest case to reach is an inner loop that ends on the instruction just before the outer loop's last one. Here the pop and the next comparison against the outer entry must fall in the same cycle. The stimulus builds two counter-driven loops with adjacent end addresses. It runs the inner body twice, then raises the counter flag and presents the outer end address as the next fetch. A full stack is reached by four loop-starts with distant end addresses. A fifth start then shows the push is lost and the old top still matches.

// File: rtl/zol_pkg.sv
package zol_pkg;

    localparam int ADDR_W = 14;
    localparam int COND_W = 4;
    localparam int LOOP_DEPTH = 4;
    localparam int FLAG_W = 7;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [COND_W-1:0] {
        CC_EQ   = 4'd0,
        CC_NE   = 4'd1,
        CC_GT   = 4'd2,
        CC_LE   = 4'd3,
        CC_LT   = 4'd4,
        CC_GE   = 4'd5,
        CC_AV   = 4'd6,
        CC_NAV  = 4'd7,
        CC_AC   = 4'd8,
        CC_NAC  = 4'd9,
        CC_XNEG = 4'd10,
        CC_XPOS = 4'd11,
        CC_MV   = 4'd12,
        CC_NMV  = 4'd13,
        CC_NCE  = 4'd14,
        CC_TRUE = 4'd15
    } cc_e;

    typedef struct packed {
        addr_t end_addr;
        cc_e   cond;
    } loop_ent_t;

    typedef struct packed {
        logic ce;
        logic mv;
        logic xs;
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;

    // Branch-style condition; a loop keeps running while this is true.
    function automatic logic cc_holds(cc_e cc, flags_t f);
        logic lt;
        lt = f.n ^ f.v;
        case (cc)
            CC_EQ:   return f.z;
            CC_NE:   return !f.z;
            CC_GT:   return !lt && !f.z;
            CC_LE:   return lt || f.z;
            CC_LT:   return lt;
            CC_GE:   return !lt;
            CC_AV:   return f.v;
            CC_NAV:  return !f.v;
            CC_AC:   return f.c;
            CC_NAC:  return !f.c;
            CC_XNEG: return f.xs;
            CC_XPOS: return !f.xs;
            CC_MV:   return f.mv;
            CC_NMV:  return !f.mv;
            CC_NCE:  return !f.ce;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic cc_tests_counter(cc_e cc);
        return cc == CC_NCE;
    endfunction

endpackage

// File: rtl/zol_stack.sv
module zol_stack #(
    parameter int DEPTH = zol_pkg::LOOP_DEPTH,
    parameter type ENT_T = zol_pkg::loop_ent_t
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  ENT_T din,
    output ENT_T top_o,
    output ENT_T below_o,
    output logic empty_o,
    output logic full_o,
    output logic push_ok_o,
    output logic pop_ok_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lvl_after_pop;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] below_idx;
    ENT_T mem [DEPTH];

    assign empty_o       = (cnt_q == '0);
    assign full_o        = (cnt_q == FULL_LVL);
    assign pop_ok_o      = pop && !empty_o;
    assign lvl_after_pop = cnt_q - CNT_W'(pop_ok_o);
    assign push_ok_o     = push && (lvl_after_pop < FULL_LVL);
    assign level_o       = cnt_q;

    assign top_idx   = IDX_W'(cnt_q - CNT_W'(1));
    assign below_idx = IDX_W'(cnt_q - CNT_W'(2));
    assign top_o     = (cnt_q >= CNT_W'(1)) ? mem[top_idx] : '0;
    assign below_o   = (cnt_q >= CNT_W'(2)) ? mem[below_idx] : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (push_ok_o && (lvl_after_pop == CNT_W'(i))) begin
                mem[i] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= lvl_after_pop + CNT_W'(push_ok_o);
        end
    end

    // R10: level never passes the depth
    p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_LVL);

    // R10: a push into a full stack with no pop leaves the level alone
    p_full_push_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (full_o && push && !pop) |=> $stable(cnt_q));

    // R9: a pop on an empty stack keeps it empty
    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop && !push) |=> (cnt_q == '0));

endmodule

// File: rtl/zol_term_eval.sv
module zol_term_eval
    import zol_pkg::*;
(
    input  logic   active,
    input  cc_e    cond,
    input  flags_t flg,
    output logic   keep_going,
    output logic   finish,
    output logic   ctr_test
);
    logic holds;

    always_comb begin
        holds      = cc_holds(cond, flg);
        keep_going = active && holds;
        finish     = active && !holds;
        ctr_test   = active && cc_tests_counter(cond);
    end
endmodule

// File: rtl/zol_cmp.sv
module zol_cmp #(
    parameter int AW = zol_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [AW-1:0] ref_addr,
    input  logic [AW-1:0] next_addr,
    output logic          hit_o,
    output logic          at_end_o
);
    logic at_end_q;

    assign hit_o    = en && (ref_addr == next_addr);
    assign at_end_o = at_end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            at_end_q <= 1'b0;
        end else begin
            at_end_q <= hit_o;
        end
    end

    // R3: the end-of-loop cycle always follows a match
    p_end_follows_hit_r3: assert property (@(posedge clk) disable iff (rst)
        at_end_q |-> $past(hit_o));
endmodule

// File: rtl/zol_loop_ctrl.sv
module zol_loop_ctrl
    import zol_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = COND_W,
    parameter int FW = FLAG_W,
    parameter int DEPTH = LOOP_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          do_valid,
    input  logic [AW-1:0] do_end_addr,
    input  logic [CW-1:0] do_cond,
    input  logic [AW-1:0] next_addr,
    input  logic [FW-1:0] flags,
    input  logic          man_pop,
    output logic          last_next,
    output logic          loop_back,
    output logic          pc_push_req,
    output logic          pc_pop_req,
    output logic          cnt_dec_req,
    output logic          cnt_pop_req,
    output logic          loop_empty,
    output logic          loop_ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    loop_ent_t        new_ent, top_ent, below_ent;
    flags_t           flg;
    logic             empty, full, push_ok, pop_ok;
    logic [CNT_W-1:0] level;
    logic             at_end, active_end;
    logic             keep_going, finish, ctr_test;
    logic             pop_any;
    logic             cmp_en;
    logic [AW-1:0]    cmp_ref;
    logic             hit;
    logic             ovf_q;
    logic             unused_below;

    assign new_ent.end_addr = do_end_addr;
    assign new_ent.cond     = cc_e'(do_cond);
    assign flg              = flags_t'(flags);
    assign unused_below     = ^below_ent.cond;

    assign active_end = at_end && !empty;
    assign pop_any    = finish || man_pop;

    zol_stack #(.DEPTH(DEPTH), .ENT_T(loop_ent_t)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (do_valid),
        .pop       (pop_any),
        .din       (new_ent),
        .top_o     (top_ent),
        .below_o   (below_ent),
        .empty_o   (empty),
        .full_o    (full),
        .push_ok_o (push_ok),
        .pop_ok_o  (pop_ok),
        .level_o   (level)
    );

    zol_term_eval u_eval (
        .active     (active_end),
        .cond       (top_ent.cond),
        .flg        (flg),
        .keep_going (keep_going),
        .finish     (finish),
        .ctr_test   (ctr_test)
    );

    // Compare against whichever entry is on top once this cycle settles.
    always_comb begin
        if (push_ok) begin
            cmp_en  = 1'b1;
            cmp_ref = do_end_addr;
        end else if (pop_ok) begin
            cmp_en  = (level >= CNT_W'(2));
            cmp_ref = below_ent.end_addr;
        end else begin
            cmp_en  = !empty;
            cmp_ref = top_ent.end_addr;
        end
    end

    zol_cmp #(.AW(AW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .en        (cmp_en),
        .ref_addr  (cmp_ref),
        .next_addr (next_addr),
        .hit_o     (hit),
        .at_end_o  (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (do_valid && !push_ok) begin
            ovf_q <= 1'b1;
        end
    end

    assign last_next   = hit;
    assign loop_back   = keep_going;
    assign pc_push_req = push_ok;
    assign pc_pop_req  = pop_ok;
    assign cnt_dec_req = ctr_test;
    assign cnt_pop_req = ctr_test && finish;
    assign loop_empty  = empty;
    assign loop_ovf    = ovf_q;

    // R10: overflow flag is sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        loop_ovf |=> loop_ovf);

    // R4: a pop without a push lowers the level by one
    p_exit_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (pc_pop_req && !pc_push_req) |=> (level == $past(level) - CNT_W'(1)));

    // R4: continuing and terminating never coincide
    p_back_or_exit_r4: assert property (@(posedge clk) disable iff (rst)
        !(loop_back && cnt_pop_req));

    // R6: count-stack pop only on a counter test that ends the loop
    p_cnt_pop_exit_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_pop_req |-> (pc_pop_req && cnt_dec_req));

    // R3: no match while the stack is empty and nothing is pushed
    p_empty_no_match_r3: assert property (@(posedge clk) disable iff (rst)
        (loop_empty && !do_valid) |-> !last_next);

    // R4: loop-back only in the cycle after a match
    p_back_after_match_r4: assert property (@(posedge clk) disable iff (rst)
        loop_back |-> $past(last_next));

    // R10: a rejected loop-start requests no push
    p_full_no_push_r10: assert property (@(posedge clk) disable iff (rst)
        (full && !pop_any) |-> !pc_push_req);
endmodule

// File: tb/sim_zol_loop_ctrl.sv
module sim_zol_loop_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        do_valid = 1'b0;
    logic [13:0] do_end_addr = '0;
    logic [3:0]  do_cond = '0;
    logic [13:0] next_addr = '0;
    logic [6:0]  flags = '0;
    logic        man_pop = 1'b0;
    logic last_next, loop_back, pc_push_req, pc_pop_req;
    logic cnt_dec_req, cnt_pop_req, loop_empty, loop_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    // flags bits: 6 ce, 5 mv, 4 xs, 3 c, 2 v, 1 n, 0 z
    localparam logic [6:0] F_NONE = 7'b0000000;
    localparam logic [6:0] F_Z    = 7'b0000001;
    localparam logic [6:0] F_N    = 7'b0000010;
    localparam logic [6:0] F_NV   = 7'b0000110;
    localparam logic [6:0] F_CE   = 7'b1000000;
    localparam logic [6:0] F_ALL  = 7'b1111111;

    always #4 clk = ~clk;

    zol_loop_ctrl u0 (
        .clk(clk), .rst(rst), .do_valid(do_valid), .do_end_addr(do_end_addr),
        .do_cond(do_cond), .next_addr(next_addr), .flags(flags), .man_pop(man_pop),
        .last_next(last_next), .loop_back(loop_back), .pc_push_req(pc_push_req),
        .pc_pop_req(pc_pop_req), .cnt_dec_req(cnt_dec_req), .cnt_pop_req(cnt_pop_req),
        .loop_empty(loop_empty), .loop_ovf(loop_ovf)
    );

    // Expected vector: {last_next, loop_back, pc_push, pc_pop, cnt_dec, cnt_pop, empty, ovf}
    task automatic step(input logic dv, input logic [13:0] ea, input logic [3:0] cc,
                        input logic [13:0] na, input logic [6:0] fl, input logic mp,
                        input logic [7:0] exp, input string tag);
        @(negedge clk);
        #1;
        do_valid    = dv;
        do_end_addr = ea;
        do_cond     = cc;
        next_addr   = na;
        flags       = fl;
        man_pop     = mp;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [13:0] na, input logic [7:0] exp, input string tag);
        step(1'b0, 14'h0, 4'h0, na, F_NONE, 1'b0, exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1;
        rst = 1'b1;
        do_valid = 1'b0;
        man_pop = 1'b0;
        flags = F_NONE;
        next_addr = '0;
        repeat (2) @(negedge clk);
        #1;
        rst = 1'b0;
    endtask

    // Monitor: compares after the driver has settled the inputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                logic [7:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {last_next, loop_back, pc_push_req, pc_pop_req,
                     cnt_dec_req, cnt_pop_req, loop_empty, loop_ovf};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", t, a, e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle(14'h000, 8'b00000010, "R1 reset state, R3 no match when empty");

        // Counter loop 0x11..0x13, code 14
        step(1'b1, 14'h013, 4'hE, 14'h011, F_NONE, 1'b0, 8'b00100010, "R2 loop-start push");
        idle(14'h012, 8'b00000000, "R11 not empty after push");
        idle(14'h013, 8'b10000000, "R3 match on end address");
        step(1'b0, 14'h0, 4'h0, 14'h011, F_NONE, 1'b0, 8'b01001000, "R6 counter test continues");
        idle(14'h012, 8'b00000000, "R4 body after loop-back");
        idle(14'h013, 8'b10000000, "R3 second match");
        step(1'b0, 14'h0, 4'h0, 14'h014, F_CE, 1'b0, 8'b00011100, "R6 counter expired exit");
        idle(14'h015, 8'b00000010, "R11 empty after exit");

        // One-instruction forever loop, left by manual pop
        step(1'b1, 14'h021, 4'hF, 14'h021, F_NONE, 1'b0, 8'b10100010, "R3 one-instruction match at push");
        idle(14'h021, 8'b11000000, "R7 forever continues");
        step(1'b0, 14'h0, 4'h0, 14'h030, F_ALL, 1'b0, 8'b01000000, "R7 forever ignores all flags");
        step(1'b0, 14'h0, 4'h0, 14'h031, F_NONE, 1'b1, 8'b00010000, "R9 manual pop");
        idle(14'h032, 8'b00000010, "R9 stack empty after manual pop");

        // Inverse encoding: code 0 keeps running while z
        step(1'b1, 14'h041, 4'h0, 14'h041, F_NONE, 1'b0, 8'b10100010, "R5 EQ loop push");
        step(1'b0, 14'h0, 4'h0, 14'h041, F_Z, 1'b0, 8'b11000000, "R5 EQ holds continues");
        step(1'b0, 14'h0, 4'h0, 14'h042, F_NONE, 1'b0, 8'b00010000, "R5 EQ fails terminates");
        idle(14'h043, 8'b00000010, "R4 empty after terminate");

        // Code 5 GE: lt = n ^ v
        step(1'b1, 14'h051, 4'h5, 14'h051, F_NONE, 1'b0, 8'b10100010, "R5 GE loop push");
        step(1'b0, 14'h0, 4'h0, 14'h051, F_NV, 1'b0, 8'b11000000, "R5 GE n=v continues");
        step(1'b0, 14'h0, 4'h0, 14'h052, F_N, 1'b0, 8'b00010000, "R5 GE n!=v terminates");
        idle(14'h053, 8'b00000010, "R11 empty");

        // Nested counter loops, inner ends just before outer end
        step(1'b1, 14'h064, 4'hE, 14'h061, F_NONE, 1'b0, 8'b00100010, "R2 outer push");
        step(1'b1, 14'h063, 4'hE, 14'h062, F_NONE, 1'b0, 8'b00100000, "R2 inner push");
        idle(14'h063, 8'b10000000, "R8 inner match");
        step(1'b0, 14'h0, 4'h0, 14'h062, F_NONE, 1'b0, 8'b01001000, "R8 inner continues");
        idle(14'h063, 8'b10000000, "R8 inner match again");
        step(1'b0, 14'h0, 4'h0, 14'h064, F_CE, 1'b0, 8'b10011100, "R8 inner exit with outer match same cycle");
        step(1'b0, 14'h0, 4'h0, 14'h061, F_NONE, 1'b0, 8'b01001000, "R8 outer loops back");
        step(1'b0, 14'h0, 4'h0, 14'h070, F_NONE, 1'b1, 8'b00010000, "R9 manual pop outer");
        idle(14'h071, 8'b00000010, "R11 empty after nest");

        // Overflow
        step(1'b1, 14'h100, 4'hF, 14'h200, F_NONE, 1'b0, 8'b00100010, "R10 fill 1");
        step(1'b1, 14'h101, 4'hF, 14'h200, F_NONE, 1'b0, 8'b00100000, "R10 fill 2");
        step(1'b1, 14'h102, 4'hF, 14'h200, F_NONE, 1'b0, 8'b00100000, "R10 fill 3");
        step(1'b1, 14'h103, 4'hF, 14'h200, F_NONE, 1'b0, 8'b00100000, "R10 fill 4");
        step(1'b1, 14'h104, 4'hF, 14'h200, F_NONE, 1'b0, 8'b00000000, "R10 fifth push rejected");
        idle(14'h103, 8'b10000001, "R10 flag set and old top kept");
        idle(14'h200, 8'b01000001, "R10 old top still forever");
        idle(14'h104, 8'b00000001, "R10 lost entry never matches");
        for (int k = 0; k < 4; k++)
            step(1'b0, 14'h0, 4'h0, 14'h200, F_NONE, 1'b1, 8'b00010001, "R9 drain pop");
        step(1'b0, 14'h0, 4'h0, 14'h200, F_NONE, 1'b1, 8'b00000011, "R9 pop on empty ignored");
        idle(14'h200, 8'b00000011, "R10 flag sticky");

        do_reset();
        idle(14'h000, 8'b00000010, "R1 reset clears overflow");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule